// File: doc/BRIEF.md
# Split Instruction/Data Memory Address Mapper

This block sits between a small processor and its on-chip memories. It takes a word address from the processor's load/store port and steers the access to one of three targets: a program store, a data store, or a small bank of memory-mapped IO registers. It produces the matching read data and generates the write enable for each target. A separate fetch port, driven only by the program counter, reaches the program store through that store's second port.

Every target sits in one word-addressed map. Program words occupy addresses 0 to 255. Data words occupy 256 to 1279. Five IO registers start at 1280. Any address from 1285 upward is unmapped. Through the load/store port, program words can be read as data but never overwritten. The fetch port is only 8 bits wide, so it cannot address data memory or IO at all.

The IO registers reset to zero, and their contents are always visible on a debug output. The program store comes up holding a computed pattern. This stands in for a loaded program.

Top module: `mem_mapper`

## Requirements
- R1: Program word i (0..255) initialises to 0x13000013 + i*0x00010203 (mod 2^32). A load/store read of address i returns that word, so a read of address 0 returns the first program word.
- R2: `fetch_data` returns the program word at `fetch_addr` one clock after that address is presented. The fetch port can address only the 256 program words.
- R3: A load/store access to address A in 256..1279 reaches data word A-256. Address 256 maps to data word 0 and address 1279 maps to data word 1023. A written value reads back unchanged.
- R4: A load/store write to address 1280+k (k = 0..4) sets IO register k, and a later read of that address returns the value.
- R5: After reset all IO registers read zero. `io_out` always carries IO register k on bits [32k+31:32k].
- R6: Load/store writes to addresses 0..255 are ignored. The program word reads the same afterwards through both the load/store port and the fetch port.
- R7: Load/store writes to addresses 1285 and above change nothing. Reads of those addresses return zero.
- R8: Load/store read data appears one clock after the address, and consecutive reads may target different regions. A read and a write to the same address in the same cycle return the value held before the write.
- R9: A fetch and a load/store read of the program store in the same cycle, at different addresses, both return their own words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | 8 | Program-counter word address for instruction fetch |
| fetch_data | output | 32 | Fetched program word, one cycle after the address |
| ls_addr | input | 11 | Load/store word address in the unified map |
| ls_we | input | 1 | Load/store write enable |
| ls_wdata | input | 32 | Load/store write data |
| ls_rdata | output | 32 | Load/store read data, one cycle after the address |
| io_out | output | 160 | Current values of the five IO registers, register k on bits [32k+31:32k] |

## Verification
The hardest case to reach is the registered bank select. It must follow each read address into the next cycle, even when consecutive reads jump between regions. The stimulus therefore issues unbroken runs of one-cycle accesses that hop between the program region, the data region, IO and unmapped space. It also lands a write and a read on the same data word in the same cycle. A scoreboard queue pairs each issued access with the result it expects one clock later. The queue also carries a fetch address that differs from the load/store address, so both program-store ports are checked in the same cycle.

// File: rtl/mm_pkg.sv
// Package: shared types and helpers for the memory mapper.
// Assumes word addressing throughout; no byte lanes.
package mm_pkg;

    // Target of a load/store access
    typedef enum logic [1:0] {
        BANK_NONE  = 2'd0,
        BANK_INSTR = 2'd1,
        BANK_DATA  = 2'd2,
        BANK_IO    = 2'd3
    } bank_e;

    // Power-up content of program word i: base plus i times step
    function automatic logic [31:0] prog_init_word(input int idx,
                                                   input logic [31:0] base,
                                                   input logic [31:0] step);
        return base + (step * 32'(idx));
    endfunction

endpackage

// File: rtl/mm_decode.sv
// Module: mm_decode
// Purely combinational decode of a load/store word address into a target
// bank and a per-bank index, and gating of the write enable per bank.
// Assumes regions are laid out back to back: program, data, IO, then unmapped.
module mm_decode
    import mm_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int IMEM_DEPTH = 256,
    parameter int DMEM_DEPTH = 1024,
    parameter int IO_COUNT   = 5,
    localparam int IM_AW     = $clog2(IMEM_DEPTH),
    localparam int DM_AW     = $clog2(DMEM_DEPTH),
    localparam int IO_AW     = (IO_COUNT > 1) ? $clog2(IO_COUNT) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output bank_e             bank,
    output logic [IM_AW-1:0]  im_idx,
    output logic [DM_AW-1:0]  dm_idx,
    output logic [IO_AW-1:0]  io_idx,
    output logic              dm_we,
    output logic              io_we
);
    localparam int DMEM_BASE = IMEM_DEPTH;
    localparam int IO_BASE   = DMEM_BASE + DMEM_DEPTH;
    localparam int MAP_END   = IO_BASE + IO_COUNT;
    localparam logic [ADDR_W-1:0] DMEM_BASE_A = ADDR_W'(DMEM_BASE);
    localparam logic [ADDR_W-1:0] IO_BASE_A   = ADDR_W'(IO_BASE);
    localparam logic [ADDR_W-1:0] MAP_END_A   = ADDR_W'(MAP_END);

    logic [ADDR_W-1:0] dm_off;
    logic [ADDR_W-1:0] io_off;

    // Region compare: pick the bank the address falls in
    always_comb begin
        if (addr < DMEM_BASE_A)      bank = BANK_INSTR;
        else if (addr < IO_BASE_A)   bank = BANK_DATA;
        else if (addr < MAP_END_A)   bank = BANK_IO;
        else                         bank = BANK_NONE;
    end

    // Offsets relative to each region base
    always_comb begin
        dm_off = addr - DMEM_BASE_A;
        io_off = addr - IO_BASE_A;
    end

    assign im_idx = IM_AW'(addr);
    assign dm_idx = DM_AW'(dm_off);
    assign io_idx = IO_AW'(io_off);

    // Write steering: program region and unmapped space take no writes
    assign dm_we = we && (bank == BANK_DATA);
    assign io_we = we && (bank == BANK_IO);

endmodule

// File: rtl/mm_imem.sv
// Module: mm_imem
// Behavioural two-port program store. Port F is the fetch port, port D the
// load/store side; both are read-only with one cycle of read latency.
// Assumes content is fixed at power-up from a computed pattern.
module mm_imem
    import mm_pkg::*;
#(
    parameter int          DEPTH     = 256,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] INIT_BASE = 32'h1300_0013,
    parameter logic [31:0] INIT_STEP = 32'h0001_0203,
    localparam int         AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     f_addr,
    output logic [DATA_W-1:0] f_data,
    input  logic [AW-1:0]     d_addr,
    output logic [DATA_W-1:0] d_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Power-up content: stands in for a loaded program image
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = DATA_W'(prog_init_word(i, INIT_BASE, INIT_STEP));
        end
    end

    // Fetch port read, one cycle latency
    always_ff @(posedge clk) begin
        f_data <= mem[f_addr];
    end

    // Load/store port read, one cycle latency
    always_ff @(posedge clk) begin
        d_data <= mem[d_addr];
    end

endmodule

// File: rtl/mm_dmem.sv
// Module: mm_dmem
// Behavioural single-port data store with synchronous write and
// read-first synchronous read. Contents are not reset.
module mm_dmem #(
    parameter int  DEPTH  = 1024,
    parameter int  DATA_W = 32,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write, then registered read of the old word at the same address
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end

endmodule

// File: rtl/mm_io_bank.sv
// Module: mm_io_bank
// Small bank of read/write registers. Reset to zero, registered read-first
// read port, and a flat view of every register for debug.
module mm_io_bank #(
    parameter int  COUNT  = 5,
    parameter int  DATA_W = 32,
    localparam int AW     = (COUNT > 1) ? $clog2(COUNT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           idx,
    input  logic                    we,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic [COUNT*DATA_W-1:0] flat
);
    logic [DATA_W-1:0] regs [COUNT];

    // Register update with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < COUNT; k++) regs[k] <= '0;
        end else if (we && (int'(idx) < COUNT)) begin
            regs[idx] <= wdata;
        end
    end

    // Registered read of the addressed register
    always_ff @(posedge clk) begin
        if (!rst_n)                   rdata <= '0;
        else if (int'(idx) < COUNT)   rdata <= regs[idx];
        else                          rdata <= '0;
    end

    // Flat debug view, register k on slice k
    for (genvar k = 0; k < COUNT; k++) begin : g_flat
        assign flat[k*DATA_W +: DATA_W] = regs[k];
    end

    // R4
    io_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (int'(idx) < COUNT)) |=> (regs[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/mem_mapper.sv
// Module: mem_mapper
// Top of the address mapper. Decodes the load/store address, drives the
// per-bank write enables, registers the bank select next to the synchronous
// reads and muxes the right read data out one cycle later. The fetch port
// is wired straight to the program store and cannot reach other banks.
module mem_mapper
    import mm_pkg::*;
#(
    parameter int          ADDR_W     = 11,
    parameter int          DATA_W     = 32,
    parameter int          IMEM_DEPTH = 256,
    parameter int          DMEM_DEPTH = 1024,
    parameter int          IO_COUNT   = 5,
    parameter logic [31:0] INIT_BASE  = 32'h1300_0013,
    parameter logic [31:0] INIT_STEP  = 32'h0001_0203,
    localparam int         IM_AW      = $clog2(IMEM_DEPTH),
    localparam int         DM_AW      = $clog2(DMEM_DEPTH),
    localparam int         IO_AW      = (IO_COUNT > 1) ? $clog2(IO_COUNT) : 1,
    localparam int         MAP_END    = IMEM_DEPTH + DMEM_DEPTH + IO_COUNT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IM_AW-1:0]           fetch_addr,
    output logic [DATA_W-1:0]          fetch_data,
    input  logic [ADDR_W-1:0]          ls_addr,
    input  logic                       ls_we,
    input  logic [DATA_W-1:0]          ls_wdata,
    output logic [DATA_W-1:0]          ls_rdata,
    output logic [IO_COUNT*DATA_W-1:0] io_out
);
    bank_e             bank_d;
    bank_e             bank_q;
    logic [IM_AW-1:0]  im_idx;
    logic [DM_AW-1:0]  dm_idx;
    logic [IO_AW-1:0]  io_idx;
    logic              dm_we;
    logic              io_we;
    logic [DATA_W-1:0] im_rd;
    logic [DATA_W-1:0] dm_rd;
    logic [DATA_W-1:0] io_rd;

    mm_decode #(
        .ADDR_W(ADDR_W), .IMEM_DEPTH(IMEM_DEPTH),
        .DMEM_DEPTH(DMEM_DEPTH), .IO_COUNT(IO_COUNT)
    ) u_decode (
        .addr(ls_addr), .we(ls_we), .bank(bank_d),
        .im_idx(im_idx), .dm_idx(dm_idx), .io_idx(io_idx),
        .dm_we(dm_we), .io_we(io_we)
    );

    mm_imem #(
        .DEPTH(IMEM_DEPTH), .DATA_W(DATA_W),
        .INIT_BASE(INIT_BASE), .INIT_STEP(INIT_STEP)
    ) u_imem (
        .clk(clk), .f_addr(fetch_addr), .f_data(fetch_data),
        .d_addr(im_idx), .d_data(im_rd)
    );

    mm_dmem #(
        .DEPTH(DMEM_DEPTH), .DATA_W(DATA_W)
    ) u_dmem (
        .clk(clk), .addr(dm_idx), .we(dm_we),
        .wdata(ls_wdata), .rdata(dm_rd)
    );

    mm_io_bank #(
        .COUNT(IO_COUNT), .DATA_W(DATA_W)
    ) u_io (
        .clk(clk), .rst_n(rst_n), .idx(io_idx), .we(io_we),
        .wdata(ls_wdata), .rdata(io_rd), .flat(io_out)
    );

    // Bank select follows the address into the read-data cycle
    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= BANK_NONE;
        else        bank_q <= bank_d;
    end

    // Read-data mux driven by the registered select
    always_comb begin
        case (bank_q)
            BANK_INSTR: ls_rdata = im_rd;
            BANK_DATA:  ls_rdata = dm_rd;
            BANK_IO:    ls_rdata = io_rd;
            default:    ls_rdata = '0;
        endcase
    end

    // R6
    instr_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_we && (int'(ls_addr) < IMEM_DEPTH)) |-> (!dm_we && !io_we));

    // R7
    unmapped_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_we && (int'(ls_addr) >= MAP_END)) |=> $stable(io_out));

    // R7
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (int'($past(ls_addr)) >= MAP_END)) |-> (ls_rdata == '0));

    // R5
    io_reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (io_out == '0));

    // R3
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dm_we, io_we}));

endmodule

// File: tb/tb_mem_mapper.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task issues one access per cycle and queues
// the expected read and fetch data; the monitor pops one item per cycle.
module tb_mem_mapper;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [7:0]   fetch_addr;
    logic [31:0]  fetch_data;
    logic [10:0]  ls_addr;
    logic         ls_we;
    logic [31:0]  ls_wdata;
    logic [31:0]  ls_rdata;
    logic [159:0] io_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] rd_exp;
        bit          rd_chk;
        logic [31:0] f_exp;
        int          req;
    } item_t;

    item_t       q[$];
    logic [31:0] dm_sh [1024];
    bit          dm_ok [1024];
    logic [31:0] io_sh [5];

    always #4 clk = ~clk;

    mem_mapper dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .ls_addr(ls_addr), .ls_we(ls_we), .ls_wdata(ls_wdata),
        .ls_rdata(ls_rdata), .io_out(io_out)
    );

    function automatic logic [31:0] prog_word(input int i);
        return 32'h1300_0013 + 32'(i) * 32'h0001_0203;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present one access, queue what the next cycle must show
    task automatic acc(input int a, input bit we, input logic [31:0] wd,
                       input int fa, input int req);
        item_t it;
        ls_addr    = 11'(a);
        ls_we      = we;
        ls_wdata   = wd;
        fetch_addr = 8'(fa);
        it.rd_chk  = 1'b1;
        it.req     = req;
        it.f_exp   = prog_word(fa);
        if (a < 256)       it.rd_exp = prog_word(a);
        else if (a < 1280) begin
            it.rd_exp = dm_sh[a-256];
            it.rd_chk = dm_ok[a-256];
        end
        else if (a < 1285) it.rd_exp = io_sh[a-1280];
        else               it.rd_exp = 32'h0;
        q.push_back(it);
        if (we) begin
            if (a >= 256 && a < 1280) begin
                dm_sh[a-256] = wd;
                dm_ok[a-256] = 1'b1;
            end else if (a >= 1280 && a < 1285) begin
                io_sh[a-1280] = wd;
            end
        end
        @(negedge clk);
        ls_we = 1'b0;
    endtask

    // Monitor: compare one queued item per clock, away from the edge
    always begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.rd_chk) check($sformatf("R%0d ls_rdata", it.req), ls_rdata, it.rd_exp);
            check($sformatf("R%0d fetch_data", it.req), fetch_data, it.f_exp);
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) dm_ok[i] = 1'b0;
        for (int k = 0; k < 5; k++) io_sh[k] = 32'h0;
        rst_n = 1'b0; ls_addr = '0; ls_we = 1'b0; ls_wdata = '0; fetch_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: reset state of the IO bank
        check("R5 io_out after reset", io_out[31:0] | io_out[63:32] | io_out[95:64]
              | io_out[127:96] | io_out[159:128], 32'h0);
        for (int k = 0; k < 5; k++) acc(1280 + k, 1'b0, '0, k, 5);

        // R1, R9: program words through the data port, fetch elsewhere
        acc(0, 1'b0, '0, 200, 1);
        acc(1, 1'b0, '0, 17, 9);
        acc(255, 1'b0, '0, 0, 1);
        // R2: fetch sweep at the ends of the program store
        acc(128, 1'b0, '0, 255, 2);

        // R3: data region ends and a middle word
        acc(256, 1'b1, 32'hDEAD_0000, 3, 3);
        acc(1279, 1'b1, 32'hDEAD_03FF, 4, 3);
        acc(700, 1'b1, 32'h1234_5678, 5, 3);
        acc(256, 1'b0, '0, 6, 3);
        acc(1279, 1'b0, '0, 7, 3);
        acc(700, 1'b0, '0, 8, 3);
        // R8: same-cycle write and read returns the old word, then the new
        acc(700, 1'b1, 32'hCAFE_F00D, 9, 8);
        acc(700, 1'b0, '0, 10, 8);

        // R4: IO writes and readback
        for (int k = 0; k < 5; k++) acc(1280 + k, 1'b1, 32'hA0A0_0000 + 32'(k), 11, 4);
        for (int k = 0; k < 5; k++) acc(1280 + k, 1'b0, '0, 12, 4);
        // R5: debug view layout
        for (int k = 0; k < 5; k++)
            check($sformatf("R5 io_out slice %0d", k), io_out[k*32 +: 32], io_sh[k]);

        // R6: writes into the program region are dropped
        acc(5, 1'b1, 32'hFFFF_FFFF, 5, 6);
        acc(255, 1'b1, 32'h0BAD_0BAD, 255, 6);
        acc(5, 1'b0, '0, 5, 6);
        acc(255, 1'b0, '0, 255, 6);

        // R7: unmapped writes and reads
        acc(1285, 1'b1, 32'h5555_5555, 20, 7);
        acc(2047, 1'b1, 32'h6666_6666, 21, 7);
        acc(1285, 1'b0, '0, 22, 7);
        acc(2047, 1'b0, '0, 23, 7);
        for (int k = 0; k < 5; k++)
            check($sformatf("R7 io_out slice %0d unchanged", k), io_out[k*32 +: 32], io_sh[k]);
        acc(1279, 1'b0, '0, 24, 7);

        // R8: back-to-back reads hopping across every region
        acc(2, 1'b0, '0, 30, 8);
        acc(256, 1'b0, '0, 31, 8);
        acc(1284, 1'b0, '0, 32, 8);
        acc(1500, 1'b0, '0, 33, 8);
        acc(1280, 1'b0, '0, 34, 8);
        acc(3, 1'b0, '0, 35, 8);
        acc(700, 1'b0, '0, 36, 8);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule